// File: doc/BRIEF.md
# Two-Road Crossing Light Sequencer

This block drives the lamps of a crossing between an east-west road and a north-south road. It walks through a fixed loop of eight light patterns. Each pattern appears as one 8-bit word, laid out the way a processor would write it to a light output port. A small state machine holds the current step. A dwell timer decides how many enabled clock cycles each step lasts. A combinational encoder turns the step into the lamp word.

Each road gets a British-style go phase: red with amber, then green, then amber alone. Both roads show red for one clearance step before each go phase, and the east-west road always goes first. The surrounding logic sets the step length through the `dwell` input. It can stall the loop with `en`. It can use `step_pulse` to see the moment a new pattern appears.

The states, in loop order, are:

| State | Word | Meaning |
|---|---|---|
| ST_CLEAR_EW | 0x90 | all red |
| ST_EW_PREP | 0xD0 | east-west red+amber |
| ST_EW_GO | 0x30 | east-west green |
| ST_EW_STOP | 0x50 | east-west amber |
| ST_CLEAR_NS | 0x90 | all red |
| ST_NS_PREP | 0x98 | north-south red+amber |
| ST_NS_GO | 0x84 | north-south green |
| ST_NS_STOP | 0x88 | north-south amber |

There are two transitions:

- **advance** moves to the next row and wraps from ST_NS_STOP to ST_CLEAR_EW. It is taken when the dwell of the current step has run out while `en` is high.
- **restart** goes from any state to ST_CLEAR_EW when `rst` is high.

Top module: `xroad_light_seq`

## Requirements
- R1: A synchronous reset gives `lamp_byte` = 0x90, `step_idx` = 0 and `step_pulse` = 0 on the next cycle.
- R2: In `lamp_byte`, bits 7/6/5 are east-west red/amber/green and bits 4/3/2 are north-south red/amber/green. Bits 1:0 are always 0.
- R3: Step indices 0..7 produce the words 0x90, 0xD0, 0x30, 0x50, 0x90, 0x98, 0x84, 0x88 in that order. After index 7 the loop wraps to index 0.
- R4: Each step lasts exactly `dwell` enabled cycles. The value is sampled on the edge that enters the step, or on the reset edge for the first step. Later changes to `dwell` do not alter the current step.
- R5: A `dwell` value of 0 acts as 1, so the step advances on every enabled cycle.
- R6: While `en` is low, `lamp_byte` and `step_idx` hold, the dwell count pauses, and `step_pulse` stays 0.
- R7: `step_pulse` is 1 for exactly the one cycle in which a new step's word first appears, and 0 at all other times.
- R8: The two green bits are never set together. A road's green bit is never set while the other road's red bit is clear.
- R9: When reset arrives in the same cycle that a step change is due, reset wins: index 0 is shown and no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the sequencer |
| dwell | input | DWELL_W | Step length in enabled clock cycles (0 acts as 1) |
| lamp_byte | output | 8 | Lamp word for the current step |
| step_idx | output | 3 | Current step index, 0..7 |
| step_pulse | output | 1 | One-cycle marker of a new step |

## Verification
A due step change can fall in the same cycle as a reset, and a step entry can fall in the same cycle as a change on `dwell`. The bench provokes the first case by raising reset exactly when its own model says the last dwell cycle of a step is under way. The result is judged by index 0, word 0x90 and no pulse. The bench provokes the second case by rewriting `dwell` mid-step and around step edges while `en` toggles. A behavioural model compares word, index and pulse on every clock, so a step that samples the wrong dwell value shows up as a timing mismatch.

// File: rtl/xroad_pkg.sv
package xroad_pkg;
    localparam int NUM_STEPS = 8;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int LAMP_W    = 8;

    typedef enum logic [STEP_W-1:0] {
        ST_CLEAR_EW = 3'd0,
        ST_EW_PREP  = 3'd1,
        ST_EW_GO    = 3'd2,
        ST_EW_STOP  = 3'd3,
        ST_CLEAR_NS = 3'd4,
        ST_NS_PREP  = 3'd5,
        ST_NS_GO    = 3'd6,
        ST_NS_STOP  = 3'd7
    } step_e;

    typedef struct packed {
        logic       ew_red;
        logic       ew_amber;
        logic       ew_green;
        logic       ns_red;
        logic       ns_amber;
        logic       ns_green;
        logic [1:0] spare;
    } lamp_t;
endpackage

// File: rtl/xroad_dwell_timer.sv
module xroad_dwell_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [DWELL_W-1:0] dwell,
    output logic               expire
);
    localparam logic [DWELL_W-1:0] ONE = DWELL_W'(1);

    logic [DWELL_W-1:0] limit_q;
    logic [DWELL_W-1:0] elapsed_q;
    logic [DWELL_W-1:0] floor_dwell;

    always_comb floor_dwell = (dwell == '0) ? ONE : dwell;

    assign expire = en && (elapsed_q == limit_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q   <= floor_dwell;
            elapsed_q <= '0;
        end else if (en) begin
            if (expire) begin
                limit_q   <= floor_dwell;
                elapsed_q <= '0;
            end else begin
                elapsed_q <= elapsed_q + ONE;
            end
        end
    end

    p_limit_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        limit_q != '0);

    p_elapsed_bound_r4: assert property (@(posedge clk) disable iff (rst)
        elapsed_q < limit_q);

    p_pause_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(rst)) |=> $stable(elapsed_q) && $stable(limit_q));
endmodule

// File: rtl/xroad_step_fsm.sv
module xroad_step_fsm
    import xroad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    output step_e step_q,
    output logic  pulse_q
);
    step_e step_d;

    always_comb begin
        step_d = step_q;
        if (advance) begin
            unique case (step_q)
                ST_CLEAR_EW: step_d = ST_EW_PREP;
                ST_EW_PREP:  step_d = ST_EW_GO;
                ST_EW_GO:    step_d = ST_EW_STOP;
                ST_EW_STOP:  step_d = ST_CLEAR_NS;
                ST_CLEAR_NS: step_d = ST_NS_PREP;
                ST_NS_PREP:  step_d = ST_NS_GO;
                ST_NS_GO:    step_d = ST_NS_STOP;
                ST_NS_STOP:  step_d = ST_CLEAR_EW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_CLEAR_EW;
            pulse_q <= 1'b0;
        end else begin
            step_q  <= step_d;
            pulse_q <= advance;
        end
    end

    p_next_in_order_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_q != $past(step_q)) |->
            step_q == step_e'($past(step_q) + 3'd1));

    p_pulse_means_change_r7: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> step_q != $past(step_q));

    p_change_gives_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_q != $past(step_q)) |-> pulse_q);

    p_reset_wins_r9: assert property (@(posedge clk)
        rst |=> (step_q == ST_CLEAR_EW) && !pulse_q);
endmodule

// File: rtl/xroad_lamp_encode.sv
module xroad_lamp_encode
    import xroad_pkg::*;
(
    input  step_e step,
    output lamp_t lamps
);
    always_comb begin
        lamps = '{ew_red: 1'b1, ew_amber: 1'b0, ew_green: 1'b0,
                  ns_red: 1'b1, ns_amber: 1'b0, ns_green: 1'b0, spare: 2'b00};
        unique case (step)
            ST_CLEAR_EW, ST_CLEAR_NS: ;
            ST_EW_PREP: lamps.ew_amber = 1'b1;
            ST_EW_GO: begin
                lamps.ew_red   = 1'b0;
                lamps.ew_green = 1'b1;
            end
            ST_EW_STOP: begin
                lamps.ew_red   = 1'b0;
                lamps.ew_amber = 1'b1;
            end
            ST_NS_PREP: lamps.ns_amber = 1'b1;
            ST_NS_GO: begin
                lamps.ns_red   = 1'b0;
                lamps.ns_green = 1'b1;
            end
            ST_NS_STOP: begin
                lamps.ns_red   = 1'b0;
                lamps.ns_amber = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xroad_light_seq.sv
module xroad_light_seq
    import xroad_pkg::*;
#(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [DWELL_W-1:0] dwell,
    output logic [LAMP_W-1:0]  lamp_byte,
    output logic [STEP_W-1:0]  step_idx,
    output logic               step_pulse
);
    logic  expire;
    step_e step;
    lamp_t lamps;

    xroad_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .dwell  (dwell),
        .expire (expire)
    );

    xroad_step_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .advance (expire),
        .step_q  (step),
        .pulse_q (step_pulse)
    );

    xroad_lamp_encode u_enc (
        .step  (step),
        .lamps (lamps)
    );

    assign lamp_byte = lamps;
    assign step_idx  = step;

    p_greens_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(lamp_byte[5] && lamp_byte[2]));

    p_green_needs_cross_red_r8: assert property (@(posedge clk) disable iff (rst)
        (lamp_byte[5] -> lamp_byte[4]) && (lamp_byte[2] -> lamp_byte[7]));

    p_spare_low_r2: assert property (@(posedge clk) disable iff (rst)
        lamp_byte[1:0] == 2'b00);

    p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(rst)) |=> $stable(step_idx) && !step_pulse);
endmodule

// File: tb/sim_xroad_light_seq.sv
module sim_xroad_light_seq;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [DW-1:0] dwell = 16'd3;
    logic [7:0]    lamp_byte;
    logic [2:0]    step_idx;
    logic          step_pulse;

    always #4 clk = ~clk;

    xroad_light_seq #(.DWELL_W(DW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .dwell      (dwell),
        .lamp_byte  (lamp_byte),
        .step_idx   (step_idx),
        .step_pulse (step_pulse)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R3";
    bit    armed = 1'b0;
    bit    done  = 1'b0;

    int ref_word [8] = '{8'h90, 8'hD0, 8'h30, 8'h50, 8'h90, 8'h98, 8'h84, 8'h88};
    int m_step = 0;
    int m_left = 1;
    int m_pulse = 0;

    function automatic int floor1(int d);
        return (d == 0) ? 1 : d;
    endfunction

    // behavioural reference: remaining-cycles count per step
    always @(posedge clk) begin
        if (rst) begin
            m_step  <= 0;
            m_left  <= floor1(int'(dwell));
            m_pulse <= 0;
        end else if (en) begin
            if (m_left == 1) begin
                m_step  <= (m_step + 1) % 8;
                m_left  <= floor1(int'(dwell));
                m_pulse <= 1;
            end else begin
                m_left  <= m_left - 1;
                m_pulse <= 0;
            end
        end else begin
            m_pulse <= 0;
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk(cur_req, int'(lamp_byte), ref_word[m_step], "lamp_byte");
            chk(cur_req, int'(step_idx), m_step, "step_idx");
            chk("R7", int'(step_pulse), m_pulse, "step_pulse");
            chk("R8", int'((lamp_byte[5] & lamp_byte[2]) | (lamp_byte[5] & ~lamp_byte[4])
                         | (lamp_byte[2] & ~lamp_byte[7])), 0, "green safety");
            chk("R2", int'(lamp_byte[1:0]), 0, "spare bits");
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        armed = 1'b1;
        chk("R1", int'(lamp_byte), 8'h90, "reset word");
        chk("R1", int'(step_idx), 0, "reset index");
        chk("R1", int'(step_pulse), 0, "reset pulse");
        rst = 1'b0;
        en  = 1'b1;
        cur_req = "R3";
        repeat (30) @(negedge clk);
        cur_req = "R5";
        dwell = 16'd0;
        repeat (20) @(negedge clk);
        cur_req = "R4";
        dwell = 16'd5;
        repeat (6) @(negedge clk);
        dwell = 16'd2;
        repeat (3) @(negedge clk);
        dwell = 16'd4;
        repeat (25) @(negedge clk);
        cur_req = "R6";
        for (int i = 0; i < 45; i++) begin
            en = (i % 3) != 0;
            if (i == 20) dwell = 16'd1;
            @(negedge clk);
        end
        en = 1'b1;
        cur_req = "R9";
        dwell = 16'd2;
        repeat (3) @(negedge clk);
        while (m_left != 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9", int'(step_idx), 0, "index after reset at due step");
        chk("R9", int'(step_pulse), 0, "pulse after reset at due step");
        chk("R9", int'(lamp_byte), 8'h90, "word after reset at due step");
        rst = 1'b0;
        repeat (20) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end
endmodule